// File: doc/BRIEF.md
# Speculative Memory Ordering Buffer

This block sits between the processing units of a task-speculative processor and data memory. Every load and store issued by an active task is recorded against its address, in a fully associative set of entries. Each entry keeps one load bit, one store bit and one store data word for every task stage. A task is named by its position relative to the oldest active task: position 0 is the head, and larger positions are younger tasks.

A load returns the value stored by the nearest task at or before its own position, and reads memory when no such task has stored to that address. A store that reaches an address already loaded by a younger task raises a violation naming that task. The task queue must then squash that task and everything younger. Stores stay in the buffer until their task commits. A commit drains the head task's stores to memory one per cycle in ascending address order, then retires the head. The next task becomes position 0.

When no entry is free, a request for a new address is dropped and `full` stays high. The task queue then frees space by squashing tasks or by waiting for the head to commit.

Top module: `spec_mem_arb`

## Requirements
- R1: After reset no entry is in use, `full`, `draining`, `rsp_valid`, `viol_valid` and `mem_wr_en` are 0, and the head is position 0.
- R2: A load at position p for which no task at position 0..p holds a store to that address returns the memory word read through `mem_rd_addr` (equal to `req_addr`) in the request cycle, with `rsp_valid`=1 and `rsp_hit`=0 one cycle after the request.
- R3: A load at position p whose address holds stores from tasks at positions 0..p returns the data of the largest such position, with `rsp_hit`=1, one cycle after the request.
- R4: A store at position p raises `viol_valid` one cycle later when any task at a position greater than p has loaded that address. `viol_pos` is then the smallest such position. Loads by tasks at positions 0..p do not raise it.
- R5: Store data never reaches `mem_wr_*` before its task commits. A commit writes every head-task store, one per cycle, in strictly ascending address order, the first write appearing two cycles after the commit request.
- R6: After a commit's drain the head task's bits are cleared, the former position k becomes position k-1, and an entry left with no bits is freed.
- R7: A squash at position s clears the load and store bits of positions s and above. It causes no memory write, and later loads no longer see the squashed stores.
- R8: `full` is 1 exactly when every entry is in use. A request to a new address while full is dropped (no response, no violation). A request to an address already held is still served.
- R9: In one cycle a squash wins over a commit, and a commit wins over a request; the losers are dropped. While `draining` is 1 all requests, commits and squashes are dropped.
- R10: A commit whose head task holds n stores keeps `draining` high for n+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Memory request present |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_pos | input | TW | Head-relative task position of the request |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Store data |
| commit | input | 1 | Head task commits |
| squash_valid | input | 1 | Squash request |
| squash_pos | input | TW | First head-relative position squashed |
| mem_rd_addr | output | AW | Memory read address (combinational) |
| mem_rd_data | input | DW | Memory read data, same cycle |
| rsp_valid | output | 1 | Load response valid |
| rsp_hit | output | 1 | Response came from a buffered store |
| rsp_data | output | DW | Load data |
| viol_valid | output | 1 | Dependence violation detected |
| viol_pos | output | TW | Oldest task to squash |
| mem_wr_en | output | 1 | Commit write strobe |
| mem_wr_addr | output | AW | Commit write address |
| mem_wr_data | output | DW | Commit write data |
| full | output | 1 | No free entry |
| draining | output | 1 | A commit drain is in progress |

## Verification
The hardest states to reach are a full buffer and a violation in a task two or three places behind the store. Both depend on bits built up over many earlier requests. The bench uses a four-entry instance and walks a table in which several tasks load and store a shared address, so that each store meets younger loads that its own task did not make. Directed steps then squash a suffix of tasks, commit with stores inserted out of address order, and fill every entry. They also send a request in the same cycle as a squash, and another request in the middle of a drain.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_DRAIN = 1'b1} drain_state_e;
endpackage

// File: rtl/arb_lookup.sv
module arb_lookup #(
  parameter int ENTRIES = 256,
  parameter int AW      = 32,
  localparam int EW     = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ENTRIES-1:0]  used,
  input  logic [AW-1:0]       addr_q [ENTRIES],
  input  logic [AW-1:0]       key,
  output logic                hit,
  output logic [EW-1:0]       hit_idx,
  output logic                free_ok,
  output logic [EW-1:0]       free_idx
);
  logic [ENTRIES-1:0] match;

  always_comb begin
    hit = 1'b0; hit_idx = '0; free_ok = 1'b0; free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      match[i] = used[i] && (addr_q[i] == key);
      if (match[i]) begin hit = 1'b1; hit_idx = EW'(i); end
      if (!used[i]) begin free_ok = 1'b1; free_idx = EW'(i); end
    end
  end

  // R8
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/arb_min_pick.sv
module arb_min_pick #(
  parameter int ENTRIES = 256,
  parameter int AW      = 32,
  localparam int EW     = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] cand,
  input  logic [AW-1:0]      addr_q [ENTRIES],
  output logic               found,
  output logic [EW-1:0]      idx
);
  logic [AW-1:0] best;

  always_comb begin
    found = 1'b0; idx = '0; best = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (cand[i] && (!found || addr_q[i] < best)) begin
        found = 1'b1; idx = EW'(i); best = addr_q[i];
      end
    end
  end
endmodule

// File: rtl/spec_mem_arb.sv
module spec_mem_arb #(
  parameter int ENTRIES = 256,
  parameter int TASKS   = 4,
  parameter int AW      = 32,
  parameter int DW      = 32,
  localparam int EW     = $clog2(ENTRIES),
  localparam int TW     = $clog2(TASKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_is_store,
  input  logic [TW-1:0] req_pos,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          commit,
  input  logic          squash_valid,
  input  logic [TW-1:0] squash_pos,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic [DW-1:0] rsp_data,
  output logic          viol_valid,
  output logic [TW-1:0] viol_pos,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic          full,
  output logic          draining
);
  import arb_pkg::*;

  function automatic logic [TW-1:0] to_slot(input logic [TW-1:0] h, input logic [TW-1:0] p);
    return h + p;
  endfunction
  function automatic logic [TW-1:0] to_rel(input logic [TW-1:0] s, input logic [TW-1:0] h);
    return s - h;
  endfunction

  logic [AW-1:0]    ent_addr [ENTRIES];
  logic [DW-1:0]    ent_data [ENTRIES][TASKS];
  logic [TASKS-1:0] ent_ld   [ENTRIES];
  logic [TASKS-1:0] ent_st   [ENTRIES];
  logic [TW-1:0]    head;
  drain_state_e     state;

  logic [ENTRIES-1:0] used, drain_cand;
  logic               hit, free_ok, drain_found;
  logic [EW-1:0]      hit_idx, free_idx, tgt, drain_idx;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      used[i]       = (|ent_ld[i]) || (|ent_st[i]);
      drain_cand[i] = ent_st[i][head];
    end
  end

  arb_lookup #(.ENTRIES(ENTRIES), .AW(AW)) u_lookup (
    .clk(clk), .rst_n(rst_n), .used(used), .addr_q(ent_addr), .key(req_addr),
    .hit(hit), .hit_idx(hit_idx), .free_ok(free_ok), .free_idx(free_idx));

  arb_min_pick #(.ENTRIES(ENTRIES), .AW(AW)) u_pick (
    .cand(drain_cand), .addr_q(ent_addr), .found(drain_found), .idx(drain_idx));

  // Named events used by the datapath and by the assertions
  logic idle, acc_squash, acc_commit, acc_req, alloc;
  assign idle       = (state == ST_IDLE);
  assign acc_squash = idle && squash_valid;
  assign acc_commit = idle && !squash_valid && commit;
  assign acc_req    = idle && !squash_valid && !commit && req_valid && (hit || free_ok);
  assign alloc      = acc_req && !hit;
  assign tgt        = hit ? hit_idx : free_idx;

  assign mem_rd_addr = req_addr;
  assign full        = !free_ok;
  assign draining    = !idle;

  // Forwarding from the nearest store at or before req_pos
  logic          fwd_hit;
  logic [DW-1:0] fwd_data;
  always_comb begin
    fwd_hit = 1'b0; fwd_data = '0;
    for (int q = 0; q < TASKS; q++) begin
      if (hit && TW'(q) <= req_pos && ent_st[hit_idx][to_slot(head, TW'(q))]) begin
        fwd_hit  = 1'b1;
        fwd_data = ent_data[hit_idx][to_slot(head, TW'(q))];
      end
    end
  end

  // Oldest younger task that already loaded this address
  logic          viol_found;
  logic [TW-1:0] viol_q;
  always_comb begin
    viol_found = 1'b0; viol_q = '0;
    for (int q = TASKS - 1; q >= 0; q--) begin
      if (hit && TW'(q) > req_pos && ent_ld[hit_idx][to_slot(head, TW'(q))]) begin
        viol_found = 1'b1; viol_q = TW'(q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) ent_addr[tgt] <= req_addr;
    if (acc_req && req_is_store) ent_data[tgt][to_slot(head, req_pos)] <= req_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        ent_ld[i] <= '0;
        ent_st[i] <= '0;
      end
      head <= '0; state <= ST_IDLE;
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_data <= '0;
      viol_valid <= 1'b0; viol_pos <= '0;
      mem_wr_en <= 1'b0; mem_wr_addr <= '0; mem_wr_data <= '0;
    end else begin
      rsp_valid <= 1'b0; viol_valid <= 1'b0; mem_wr_en <= 1'b0;
      if (idle) begin
        if (acc_squash) begin
          for (int i = 0; i < ENTRIES; i++)
            for (int s = 0; s < TASKS; s++)
              if (to_rel(TW'(s), head) >= squash_pos) begin
                ent_ld[i][s] <= 1'b0;
                ent_st[i][s] <= 1'b0;
              end
        end else if (acc_commit) begin
          state <= ST_DRAIN;
        end else if (acc_req) begin
          if (req_is_store) begin
            ent_st[tgt][to_slot(head, req_pos)] <= 1'b1;
            viol_valid <= viol_found;
            viol_pos   <= viol_q;
          end else begin
            ent_ld[tgt][to_slot(head, req_pos)] <= 1'b1;
            rsp_valid <= 1'b1;
            rsp_hit   <= fwd_hit;
            rsp_data  <= fwd_hit ? fwd_data : mem_rd_data;
          end
        end
      end else if (drain_found) begin
        mem_wr_en   <= 1'b1;
        mem_wr_addr <= ent_addr[drain_idx];
        mem_wr_data <= ent_data[drain_idx][head];
        ent_st[drain_idx][head] <= 1'b0;
      end else begin
        for (int i = 0; i < ENTRIES; i++) ent_ld[i][head] <= 1'b0;
        head  <= head + 1'b1;
        state <= ST_IDLE;
      end
    end
  end

  // R5
  wr_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(draining));
  // R5
  drain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && $past(mem_wr_en)) |-> (mem_wr_addr > $past(mem_wr_addr)));
  // R4
  viol_younger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> (viol_pos > $past(req_pos)));
  // R2
  rsp_from_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_is_store && idle));
  // R9
  drain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(draining) |-> (!rsp_valid && !viol_valid));
endmodule

// File: tb/spec_mem_arb_bench.sv
module spec_mem_arb_bench;
  localparam int ENTRIES = 4, TASKS = 4, AW = 8, DW = 16, TW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_is_store = 0, commit = 0, squash_valid = 0;
  logic [TW-1:0] req_pos = '0, squash_pos = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [DW-1:0] mem_rd_data, rsp_data, mem_wr_data;
  logic rsp_valid, rsp_hit, viol_valid, mem_wr_en, full, draining;
  logic [TW-1:0] viol_pos;

  always #2 clk = ~clk;

  spec_mem_arb #(.ENTRIES(ENTRIES), .TASKS(TASKS), .AW(AW), .DW(DW)) u_spec_mem_arb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_store(req_is_store),
    .req_pos(req_pos), .req_addr(req_addr), .req_wdata(req_wdata), .commit(commit),
    .squash_valid(squash_valid), .squash_pos(squash_pos), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_data(rsp_data), .viol_valid(viol_valid), .viol_pos(viol_pos),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .full(full), .draining(draining));

  // Memory model: initial word = 3*addr+1
  logic [DW-1:0] mem [256];
  initial for (int a = 0; a < 256; a++) mem[a] = DW'(3 * a + 1);
  assign mem_rd_data = mem[mem_rd_addr];
  always @(posedge clk) if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;

  int n_chk = 0, n_bad = 0, n_wr = 0;
  logic [AW-1:0] wlog_a [8];
  logic [DW-1:0] wlog_d [8];
  always @(negedge clk) if (mem_wr_en) begin
    if (n_wr < 8) begin wlog_a[n_wr] = mem_wr_addr; wlog_d[n_wr] = mem_wr_data; end
    n_wr++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic st, input logic [TW-1:0] p, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
    req_valid = 1; req_is_store = st; req_pos = p; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic load_chk(input string req, input logic [TW-1:0] p, input logic [AW-1:0] a,
                          input logic eh, input logic [DW-1:0] ed);
    issue(0, p, a, '0);
    chk({req, " rsp_valid"}, int'(rsp_valid), 1);
    chk({req, " rsp_hit"}, int'(rsp_hit), int'(eh));
    chk({req, " rsp_data"}, int'(rsp_data), int'(ed));
  endtask

  task automatic do_squash(input logic [TW-1:0] s);
    squash_valid = 1; squash_pos = s;
    @(negedge clk);
    squash_valid = 0;
  endtask

  typedef struct packed {
    logic st; logic [TW-1:0] pos; logic [AW-1:0] addr; logic [DW-1:0] wd;
    logic ehit; logic [DW-1:0] edata; logic eviol; logic [TW-1:0] evpos;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b0, 2'd1, 8'h10, 16'h0000, 1'b0, 16'h0031, 1'b0, 2'd0},
    '{1'b1, 2'd0, 8'h10, 16'hAAAA, 1'b0, 16'h0000, 1'b1, 2'd1},
    '{1'b0, 2'd2, 8'h10, 16'h0000, 1'b1, 16'hAAAA, 1'b0, 2'd0},
    '{1'b1, 2'd2, 8'h10, 16'hBBBB, 1'b0, 16'h0000, 1'b0, 2'd0},
    '{1'b0, 2'd3, 8'h10, 16'h0000, 1'b1, 16'hBBBB, 1'b0, 2'd0},
    '{1'b0, 2'd1, 8'h10, 16'h0000, 1'b1, 16'hAAAA, 1'b0, 2'd0},
    '{1'b1, 2'd1, 8'h10, 16'hCCCC, 1'b0, 16'h0000, 1'b1, 2'd2},
    '{1'b0, 2'd2, 8'h20, 16'h0000, 1'b0, 16'h0061, 1'b0, 2'd0},
    '{1'b1, 2'd3, 8'h20, 16'hDDDD, 1'b0, 16'h0000, 1'b0, 2'd0},
    '{1'b0, 2'd3, 8'h20, 16'h0000, 1'b1, 16'hDDDD, 1'b0, 2'd0}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int dcnt, w0;
    repeat (3) @(negedge clk);
    chk("R1 full", int'(full), 0);
    chk("R1 draining", int'(draining), 0);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 viol_valid", int'(viol_valid), 0);
    chk("R1 mem_wr_en", int'(mem_wr_en), 0);

    // R2 R3 R4: table walk
    for (int k = 0; k < 10; k++) begin
      issue(VEC[k].st, VEC[k].pos, VEC[k].addr, VEC[k].wd);
      if (!VEC[k].st) begin
        chk($sformatf("R2/R3 row%0d rsp_valid", k), int'(rsp_valid), 1);
        chk($sformatf("R3 row%0d rsp_hit", k), int'(rsp_hit), int'(VEC[k].ehit));
        chk($sformatf("R2 row%0d rsp_data", k), int'(rsp_data), int'(VEC[k].edata));
      end else begin
        chk($sformatf("R4 row%0d viol_valid", k), int'(viol_valid), int'(VEC[k].eviol));
        if (VEC[k].eviol) chk($sformatf("R4 row%0d viol_pos", k), int'(viol_pos), int'(VEC[k].evpos));
      end
    end

    // R7: squash positions 2 and 3
    do_squash(2'd2);
    load_chk("R7 squashed store gone", 2'd3, 8'h20, 1'b0, 16'h0061);
    load_chk("R7 older store kept", 2'd3, 8'h10, 1'b1, 16'hCCCC);
    issue(1, 2'd0, 8'h20, 16'h1234);
    chk("R4 viol three behind", int'(viol_valid), 1);
    chk("R4 viol_pos", int'(viol_pos), 3);
    issue(1, 2'd0, 8'h08, 16'h5555);
    chk("R4 no viol", int'(viol_valid), 0);
    chk("R5 no write before commit", n_wr, 0);

    // R5 R10: commit head with three stores
    commit = 1;
    @(negedge clk);
    commit = 0;
    dcnt = 0;
    while (draining && dcnt < 10) begin dcnt++; @(negedge clk); end
    chk("R10 drain cycles", dcnt, 4);
    chk("R5 write count", n_wr, 3);
    chk("R5 first addr", int'(wlog_a[0]), 'h08);
    chk("R5 first data", int'(wlog_d[0]), 'h5555);
    chk("R5 second addr", int'(wlog_a[1]), 'h10);
    chk("R5 second data", int'(wlog_d[1]), 'hAAAA);
    chk("R5 third addr", int'(wlog_a[2]), 'h20);
    chk("R5 third data", int'(wlog_d[2]), 'h1234);

    // R6: renumbering and freeing
    load_chk("R6 former pos1 now head", 2'd0, 8'h10, 1'b1, 16'hCCCC);
    load_chk("R6 freed entry reads memory", 2'd1, 8'h08, 1'b0, 16'h5555);
    chk("R8 three used", int'(full), 0);

    // R8: fill
    issue(1, 2'd1, 8'h40, 16'h7777);
    chk("R8 store no viol", int'(viol_valid), 0);
    chk("R8 full set", int'(full), 1);
    issue(0, 2'd1, 8'h50, '0);
    chk("R8 new addr dropped", int'(rsp_valid), 0);
    chk("R8 still full", int'(full), 1);
    load_chk("R8 held addr served", 2'd1, 8'h40, 1'b1, 16'h7777);
    do_squash(2'd0);
    chk("R7 squash all frees", int'(full), 0);
    load_chk("R8 after free", 2'd0, 8'h50, 1'b0, 16'h00F1);

    // R9: squash beats request
    req_valid = 1; req_is_store = 0; req_pos = 2'd0; req_addr = 8'h10;
    squash_valid = 1; squash_pos = 2'd0;
    @(negedge clk);
    req_valid = 0; squash_valid = 0;
    chk("R9 squash wins", int'(rsp_valid), 0);
    load_chk("R5 committed word in memory", 2'd0, 8'h10, 1'b0, 16'hAAAA);

    // R9: requests dropped during drain
    do_squash(2'd0);
    issue(1, 2'd0, 8'h60, 16'h0101);
    w0 = n_wr;
    commit = 1;
    @(negedge clk);
    commit = 0;
    chk("R10 draining", int'(draining), 1);
    issue(0, 2'd1, 8'h60, '0);
    chk("R9 drain drops load", int'(rsp_valid), 0);
    chk("R5 single write", int'(mem_wr_en), 1);
    chk("R5 write addr", int'(mem_wr_addr), 'h60);
    @(negedge clk);
    chk("R10 drain ended", int'(draining), 0);
    chk("R7 no squash writes", n_wr - w0, 1);
    load_chk("R6 after second commit", 2'd0, 8'h60, 1'b0, 16'h0101);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule